// File: doc/BRIEF.md
# Dual-Compare Programmable Interval Timer

This block is a 16-bit interval timer controlled through four word-wide registers on a simple write-strobe and read-data bus. The registers are a count, a primary limit, a secondary limit and a control word. The counter advances on timer events. An event can be an internal tick taken every fourth clock, a synchronized rising edge on an external pin, or a terminal-count pulse from a companion timer that acts as a prescaler.

When the count would reach the limit that is in control, the count returns to zero on that same edge. The limit value never appears in the count register. In single-compare mode the output pin idles high and drops for one clock at each terminal count. In dual-compare mode the two limits take turns. The pin is high while the primary limit governs and low while the secondary one does, which gives a square or variable duty-cycle waveform.

Each terminal count sets a sticky flag. When the interrupt enable is set, that flag drives an interrupt line. In one-shot mode the timer stops itself.

Top module: `ivtimer`

## Requirements
- R1: Address 0 is the count register. It reads back the live count and can be written at any time, running or stopped. A write takes precedence over an event in the same cycle.
- R2: Each qualifying event while the run bit (control bit 0) is 1 raises the count by exactly one, unless that step is a terminal count.
- R3: When the incremented count equals the active limit, the count becomes 0 on that same edge. The count never holds a value equal to or above a nonzero active limit (after a count of 0 was written).
- R4: A limit of 0 means 65536 events per terminal count: the count runs through 0xFFFF and then wraps to 0 with a terminal count.
- R5: With control bit 1 (dual) at 0, the output is high except for exactly one clock low after each terminal count, giving a period of 4*primary clocks on the internal source.
- R6: With dual = 1, the output is high for primary-limit events and low for secondary-limit events, alternating. Control bit 7 (read-only) reads 1 while the secondary limit (address 2) governs and 0 while the primary (address 1) governs.
- R7: Events are taken at most once every fourth clock. The internal source (control bits 5:4 = 00) gives exactly one event per 4 clocks.
- R8: With source 01, each rising edge of ext_in counts once, falling edges count nothing, and the count updates within 6 clocks of the edge.
- R9: With source 10, each one-clock pulse on pre_tick counts once, provided the pulses are at least 4 clocks apart.
- R10: With control bit 2 (continuous) at 0, the run bit clears by itself at a terminal count: at any terminal count in single mode, and only at the end of the secondary interval in dual mode. With bit 2 at 1 the timer keeps running.
- R11: Control bit 6 is a sticky flag that is set at each terminal count and cleared by writing 0 to bit 6; writing 1 keeps it. irq equals the flag ANDed with control bit 3 (interrupt enable).
- R12: With the run bit at 0, events leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 count, 1 primary limit, 2 secondary limit, 3 control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |
| ext_in | input | 1 | External event input, asynchronous |
| pre_tick | input | 1 | Terminal-count pulse from a prescaler timer |
| tmr_out | output | 1 | Timer output waveform |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps small limit values in both compare modes. It measures the output period and pulse widths arithmetically, as 4 clocks per event. A design that let the count hold the limit for one event would stretch every period by 4 clocks, and a design that sampled every clock would shrink the periods to a quarter. It walks the count through 0xFFFF with a zero limit, which catches an off-by-one or a stuck-at-zero limit decode. It checks one-shot behaviour in dual mode, where stopping after the primary interval would leave the output low. It times the external-edge lag against the six-clock bound and confirms that falling edges and a stopped timer leave the count alone.

// File: rtl/ivt_pkg.sv
// Package: register map and control-field positions shared by the timer.
// Assumes a two-bit register address and a data bus of at least 8 bits.
package ivt_pkg;
    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_PRI   = 2'd1;
    localparam logic [1:0] ADDR_SEC   = 2'd2;
    localparam logic [1:0] ADDR_CTRL  = 2'd3;

    localparam int CB_RUN  = 0;
    localparam int CB_DUAL = 1;
    localparam int CB_CONT = 2;
    localparam int CB_IE   = 3;
    localparam int CB_SRC  = 4;
    localparam int CB_FLAG = 6;
    localparam int CB_SIDE = 7;

    typedef enum logic [1:0] {
        SRC_INT = 2'b00,
        SRC_EXT = 2'b01,
        SRC_PRE = 2'b10,
        SRC_OFF = 2'b11
    } src_e;
endpackage

// File: rtl/ivt_event_gen.sv
// Event generator: turns the selected source into single-cycle events
// aligned to a sampling slot that comes once every SLOT_DIV clocks.
// Assumes SYNC_STAGES >= 2. An arrival made between slots waits in a
// pending bit; several arrivals inside one slot window merge into one event.
module ivt_event_gen
    import ivt_pkg::*;
#(
    parameter int SLOT_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic ext_in,
    input  logic pre_tick,
    output logic evt
);
    localparam int PW = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;

    logic                   slot;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_prev;
    logic                   rise;
    logic                   arrival;
    logic                   pending;

    generate
        if (SLOT_DIV > 1) begin : g_div
            logic [PW-1:0] phase;

            // Free-running slot phase counter.
            always_ff @(posedge clk) begin
                if (!rst_n)                          phase <= '0;
                else if (phase == PW'(SLOT_DIV - 1)) phase <= '0;
                else                                 phase <= phase + 1'b1;
            end
            assign slot = (phase == PW'(SLOT_DIV - 1));

            // R7: two events are never adjacent.
            p_event_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
                evt |=> !evt);
        end else begin : g_nodiv
            assign slot = 1'b1;
        end
    endgenerate

    // Synchronizer chain for the asynchronous pin, plus previous-level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= '0;
            ext_prev <= 1'b0;
        end else begin
            sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_in};
            ext_prev <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise    = sync_q[SYNC_STAGES-1] & ~ext_prev;
    assign arrival = ((src == SRC_EXT) & rise) | ((src == SRC_PRE) & pre_tick);

    // Hold an arrival until the next sampling slot consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (slot) pending <= 1'b0;
        else           pending <= pending | arrival;
    end

    assign evt = slot & ((src == SRC_INT) | pending | arrival);
endmodule

// File: rtl/ivt_count_core.sv
// Count core: the count register and the selection between primary and
// secondary limits. A zero limit stands for 2**W events. The count clears
// on the edge where it would equal the limit. Assumes run and dual are
// register outputs.
module ivt_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         dual,
    input  logic         evt,
    input  logic         cnt_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] max_a,
    input  logic [W-1:0] max_b,
    output logic [W-1:0] cnt,
    output logic         use_b,
    output logic         hit
);
    localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

    logic [W-1:0] max_sel;
    logic [W:0]   lim;
    logic [W:0]   nxt;
    logic         step;

    assign max_sel = use_b ? max_b : max_a;
    assign lim     = (max_sel == '0) ? FULL : {1'b0, max_sel};
    assign nxt     = {1'b0, cnt} + 1'b1;
    assign step    = run & evt;
    assign hit     = step & (nxt == lim);

    // Count register: a software write wins, otherwise step or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= wdata;
        else if (hit)    cnt <= '0;
        else if (step)   cnt <= nxt[W-1:0];
    end

    // Limit selector: alternates at terminal count in dual mode only.
    always_ff @(posedge clk) begin
        if (!rst_n)     use_b <= 1'b0;
        else if (!dual) use_b <= 1'b0;
        else if (hit)   use_b <= ~use_b;
    end

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hit && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));

    p_clear_at_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cnt_wr) |=> (cnt == '0));

    p_swap_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && dual && $past(dual)) |=> (use_b != $past(use_b)));

    p_write_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata)));
endmodule

// File: rtl/ivtimer.sv
// Timer top: register file, output shaping and interrupt. Reads are
// combinational from the addressed register. Assumes W >= 8 so that the
// control word fits. In one-shot dual mode the timer stops after the
// secondary interval, so one full high/low cycle is produced.
module ivtimer
    import ivt_pkg::*;
#(
    parameter int W           = 16,
    parameter int SLOT_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         ext_in,
    input  logic         pre_tick,
    output logic         tmr_out,
    output logic         irq
);
    logic [W-1:0] max_a;
    logic [W-1:0] max_b;
    logic [W-1:0] cnt;
    logic         ctl_run;
    logic         ctl_dual;
    logic         ctl_cont;
    logic         ctl_ie;
    src_e         ctl_src;
    logic         flag_q;
    logic         tc_q;
    logic         use_b;
    logic         hit;
    logic         evt;
    logic         ctl_wr;
    logic         cnt_wr;
    logic         oneshot_stop;
    logic [7:0]   ctl_word;

    assign ctl_wr = bus_wr & (bus_addr == ADDR_CTRL);
    assign cnt_wr = bus_wr & (bus_addr == ADDR_COUNT);

    ivt_event_gen #(
        .SLOT_DIV   (SLOT_DIV),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (ctl_src),
        .ext_in  (ext_in),
        .pre_tick(pre_tick),
        .evt     (evt)
    );

    ivt_count_core #(.W(W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_run),
        .dual  (ctl_dual),
        .evt   (evt),
        .cnt_wr(cnt_wr),
        .wdata (bus_wdata),
        .max_a (max_a),
        .max_b (max_b),
        .cnt   (cnt),
        .use_b (use_b),
        .hit   (hit)
    );

    assign oneshot_stop = hit & ~ctl_cont & (~ctl_dual | use_b);

    // Limit registers, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_a <= '0;
            max_b <= '0;
        end else if (bus_wr && bus_addr == ADDR_PRI) begin
            max_a <= bus_wdata;
        end else if (bus_wr && bus_addr == ADDR_SEC) begin
            max_b <= bus_wdata;
        end
    end

    // Control fields; a write beats the one-shot self-stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_run  <= 1'b0;
            ctl_dual <= 1'b0;
            ctl_cont <= 1'b0;
            ctl_ie   <= 1'b0;
            ctl_src  <= SRC_INT;
        end else if (ctl_wr) begin
            ctl_run  <= bus_wdata[CB_RUN];
            ctl_dual <= bus_wdata[CB_DUAL];
            ctl_cont <= bus_wdata[CB_CONT];
            ctl_ie   <= bus_wdata[CB_IE];
            ctl_src  <= src_e'(bus_wdata[CB_SRC+1:CB_SRC]);
        end else if (oneshot_stop) begin
            ctl_run  <= 1'b0;
        end
    end

    // Sticky terminal flag: hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (hit)    flag_q <= 1'b1;
        else if (ctl_wr) flag_q <= flag_q & bus_wdata[CB_FLAG];
    end

    // One-clock terminal marker used for the single-compare pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= 1'b0;
        else        tc_q <= hit;
    end

    assign tmr_out = ctl_dual ? ~use_b : ~tc_q;
    assign irq     = flag_q & ctl_ie;

    assign ctl_word = {use_b, flag_q, ctl_src, ctl_ie, ctl_cont, ctl_dual, ctl_run};

    // Read multiplexer over the four registers.
    always_comb begin
        case (bus_addr)
            ADDR_COUNT: bus_rdata = cnt;
            ADDR_PRI:   bus_rdata = max_a;
            ADDR_SEC:   bus_rdata = max_b;
            default:    bus_rdata = {{(W-8){1'b0}}, ctl_word};
        endcase
    end

    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_dual && !tmr_out) |=> (tmr_out || ctl_dual));

    p_oneshot_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_stop && !ctl_wr) |=> !ctl_run);

    p_flag_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_run && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/sim_ivtimer.sv
`timescale 1ns/1ps
module sim_ivtimer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_in = 1'b0;
    logic        pre_tick = 1'b0;
    logic        tmr_out;
    logic        irq;

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    bit  done   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ivtimer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
        .pre_tick(pre_tick), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    // control: run, dual, continuous, irq enable, source, flag keep
    task automatic ctl(input bit run, input bit dual, input bit cont, input bit ie,
                       input int src, input bit keep);
        wr(2'd3, 16'((run ? 1 : 0) | (dual ? 2 : 0) | (cont ? 4 : 0) | (ie ? 8 : 0)
                   | (src << 4) | (keep ? 64 : 0)));
    endtask

    task automatic wait_out(input logic v, output int t);
        t = cyc;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (tmr_out == v) begin
                t = cyc;
                return;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int t0, t1, t2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(2'd0, d); check(d == 0, "R1 reset count", d, 0);
        rd(2'd3, d); check(d == 0, "R11 reset control", d, 0);
        check(tmr_out == 1'b1, "R5 reset output high", tmr_out, 1);
        check(irq == 1'b0, "R11 reset irq low", irq, 0);

        // R1: write and read back while stopped
        wr(2'd0, 16'h1234);
        rd(2'd0, d); check(d == 16'h1234, "R1 stopped write", d, 16'h1234);

        // R12: stopped timer ignores internal events
        repeat (40) @(negedge clk);
        rd(2'd0, d); check(d == 16'h1234, "R12 stopped holds count", d, 16'h1234);

        // R2 R3 R5 R7: single-compare sweep on the internal source
        for (int m = 1; m <= 5; m++) begin
            bit bad_max, bad_inc, bad_gap;
            int prev, last;
            ctl(0, 0, 0, 0, 0, 0);
            wr(2'd1, 16'(m));
            wr(2'd0, 16'd0);
            ctl(1, 0, 1, 0, 0, 0);
            wait_out(1'b0, t1);
            @(negedge clk);
            check(tmr_out == 1'b1, "R5 low pulse is one clock", tmr_out, 1);
            wait_out(1'b0, t2);
            check(t2 - t1 == 4 * m, "R5 R7 single period", t2 - t1, 4 * m);
            bad_max = 0; bad_inc = 0; bad_gap = 0;
            rd(2'd0, d); prev = int'(d); last = -1;
            for (int i = 0; i < 8 * m + 8; i++) begin
                @(negedge clk);
                rd(2'd0, d);
                if (int'(d) >= m) bad_max = 1;
                if (int'(d) != prev) begin
                    if (!(int'(d) == prev + 1 || d == 0)) bad_inc = 1;
                    if (last >= 0 && cyc - last != 4) bad_gap = 1;
                    last = cyc;
                    prev = int'(d);
                end
            end
            check(!bad_max, "R3 count stays below limit", bad_max, 0);
            check(!bad_inc, "R2 count steps by one or clears", bad_inc, 0);
            check(!bad_gap, "R7 events four clocks apart", bad_gap, 0);
        end

        // R6: dual-compare sweep
        for (int a = 1; a <= 3; a++) begin
            for (int b = 1; b <= 3; b++) begin
                ctl(0, 0, 0, 0, 0, 0);
                wr(2'd1, 16'(a));
                wr(2'd2, 16'(b));
                wr(2'd0, 16'd0);
                ctl(1, 1, 1, 0, 0, 0);
                wait_out(1'b0, t0);
                wait_out(1'b1, t0);
                wait_out(1'b0, t1);
                rd(2'd3, d);
                check(d[7] == 1'b1, "R6 secondary in control while low", d[7], 1);
                wait_out(1'b1, t2);
                rd(2'd3, d);
                check(d[7] == 1'b0, "R6 primary in control while high", d[7], 0);
                check(t1 - t0 == 4 * a, "R6 high time", t1 - t0, 4 * a);
                check(t2 - t1 == 4 * b, "R6 low time", t2 - t1, 4 * b);
            end
        end

        // R4: zero limit covers 65536 counts; R11 flag set
        begin
            bit saw_top, saw_pulse, saw_wrap;
            ctl(0, 0, 0, 0, 0, 0);
            wr(2'd1, 16'd0);
            wr(2'd0, 16'hFFFD);
            ctl(1, 0, 1, 0, 0, 0);
            saw_top = 0; saw_pulse = 0; saw_wrap = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                rd(2'd0, d);
                if (d == 16'hFFFF) saw_top = 1;
                if (saw_top && d == 0) saw_wrap = 1;
                if (!tmr_out) saw_pulse = 1;
            end
            check(saw_top, "R4 count reaches 0xFFFF", saw_top, 1);
            check(saw_wrap, "R4 count wraps to zero", saw_wrap, 1);
            check(saw_pulse, "R4 terminal pulse at wrap", saw_pulse, 1);
        end

        // R11: sticky flag and interrupt gating
        ctl(0, 0, 0, 0, 0, 1);
        rd(2'd3, d);
        check(d[6] == 1'b1, "R11 flag sticky", d[6], 1);
        check(irq == 1'b0, "R11 irq masked", irq, 0);
        ctl(0, 0, 0, 1, 0, 1);
        check(irq == 1'b1, "R11 irq when enabled", irq, 1);
        ctl(0, 0, 0, 1, 0, 0);
        check(irq == 1'b0, "R11 irq after clear", irq, 0);
        rd(2'd3, d);
        check(d[6] == 1'b0, "R11 flag cleared by write", d[6], 0);

        // R1: write while running
        wr(2'd1, 16'd200);
        wr(2'd0, 16'd0);
        ctl(1, 0, 1, 0, 0, 0);
        repeat (10) @(negedge clk);
        wr(2'd0, 16'h0050);
        rd(2'd0, d); check(d == 16'h0050, "R1 running write", d, 16'h0050);
        repeat (10) @(negedge clk);
        rd(2'd0, d);
        check(d == 16'h0052 || d == 16'h0053, "R1 R7 counting resumes", d, 16'h0052);

        // R8: external rising edges and lag
        ctl(0, 0, 0, 0, 1, 0);
        wr(2'd1, 16'd1000);
        wr(2'd0, 16'd0);
        ctl(1, 0, 1, 0, 1, 0);
        repeat (8) @(negedge clk);
        for (int k = 1; k <= 5; k++) begin
            int lag;
            @(negedge clk);
            ext_in = 1'b1;
            lag = 99;
            for (int j = 1; j <= 10; j++) begin
                @(negedge clk);
                rd(2'd0, d);
                if (int'(d) == k) begin
                    lag = j;
                    break;
                end
            end
            check(lag <= 6, "R8 edge lag", lag, 6);
            repeat (4) @(negedge clk);
            ext_in = 1'b0;
            repeat (10) @(negedge clk);
        end
        rd(2'd0, d); check(d == 5, "R8 rising edges only", d, 5);

        // R9: prescaler pulses
        ctl(0, 0, 0, 0, 2, 0);
        wr(2'd0, 16'd0);
        ctl(1, 0, 1, 0, 2, 0);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk); pre_tick = 1'b1;
            @(negedge clk); pre_tick = 1'b0;
            repeat (7) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        rd(2'd0, d); check(d == 7, "R9 prescale pulses counted", d, 7);

        // R10: one-shot single mode
        ctl(0, 0, 0, 0, 0, 0);
        wr(2'd1, 16'd3);
        wr(2'd0, 16'd0);
        ctl(1, 0, 0, 0, 0, 0);
        wait_out(1'b0, t1);
        rd(2'd3, d); check(d[0] == 1'b0, "R10 single one-shot stops", d[0], 0);
        repeat (40) @(negedge clk);
        rd(2'd0, d); check(d == 0, "R10 count stays after stop", d, 0);
        check(tmr_out == 1'b1, "R10 output idle after stop", tmr_out, 1);

        // R10: one-shot dual mode runs one full cycle
        ctl(0, 0, 0, 0, 0, 0);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd3);
        wr(2'd0, 16'd0);
        ctl(1, 1, 0, 0, 0, 0);
        wait_out(1'b0, t1);
        rd(2'd3, d); check(d[0] == 1'b1, "R10 dual keeps running after primary", d[0], 1);
        wait_out(1'b1, t2);
        rd(2'd3, d); check(d[0] == 1'b0, "R10 dual stops after secondary", d[0], 0);
        check(t2 - t1 == 12, "R10 dual secondary length", t2 - t1, 12);
        repeat (40) @(negedge clk);
        check(tmr_out == 1'b1, "R10 dual output stays high", tmr_out, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule